// File: doc/BRIEF.md
# Data-Line Timeout Counter

This block watches the data side of a memory-card host for three kinds of wait that may never end: the wait for a read block to begin, the wait for a card to release its busy indication (after a command with a busy response, or while it programs written data), and the wait for the CRC status token that follows a block write. All three share one counter. The wait length is set by a 4-bit exponent code. Code n gives 2^(BASE_EXP+n) timeout-clock ticks. With the default BASE_EXP of 13 this is 2^13 ticks for code 0 and 2^27 ticks for code 14.

The surrounding data-path logic pulses a start strobe when a wait begins and the matching stop strobe when the awaited event arrives. The counter advances only on cycles where the timeout-clock enable is high. If the count reaches the selected length first, a sticky error flag rises. Software clears that flag by writing one to it. The data-path soft reset also clears it and abandons any wait in progress.

Top module: `dat_timeout_unit`

## Requirements
- R1: After reset the error output is 0, no wait is in progress, and the stored code is 0.
- R2: For a code n from 0 to 14, the error rises on the clock edge of the 2^(BASE_EXP+n)-th timeout tick after the start strobe, and not on any earlier tick.
- R3: Code 15 is reserved and behaves exactly like code 14.
- R4: The count advances only on cycles where `tick_en` is 1. Idle cycles neither advance nor reset it.
- R5: A start strobe clears the count and begins a fresh wait, including when a wait is already running. A tick in the same cycle as the start is not counted.
- R6: The stop strobe that belongs to the running wait kind ends the wait without an error. A stop strobe for a different kind has no effect.
- R7: When several start strobes arrive together, read-start has priority over busy, and busy has priority over CRC-status. Only the stop strobe of the winning kind ends the wait.
- R8: The error flag stays at 1 until `err_clr` is pulsed. If a new timeout and a clear happen in the same cycle, the flag stays at 1.
- R9: `dat_sreset` clears the error flag and abandons the running wait, so that wait can no longer raise an error.
- R10: The code is captured when a start strobe is accepted. Changing `tmo_code` during a wait does not change that wait's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_code | input | 4 | Timeout exponent code |
| tick_en | input | 1 | Timeout-clock enable, one tick per high cycle |
| rd_start | input | 1 | Pulse: begin waiting for read data |
| busy_start | input | 1 | Pulse: begin watching busy |
| crc_start | input | 1 | Pulse: begin waiting for CRC status token |
| rd_seen | input | 1 | Pulse: read data started |
| busy_gone | input | 1 | Pulse: busy released |
| crc_seen | input | 1 | Pulse: CRC status token received |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| dat_sreset | input | 1 | Data-path soft reset |
| tmo_err | output | 1 | Sticky timeout error |

## Verification
The bench targets the exact terminal tick. An off-by-one counter would raise the error one tick early or one tick late. It also checks that the reserved code 15 runs the full code-14 length; a design without the clamp would overflow or never time out. Further cases cover a start that lands on a tick, a restart in the middle of a wait, a stop strobe of the wrong kind, a code change during a wait, and a timeout in the same cycle as a clear. Each of these exposes a design that counts the wrong tick, stops on the wrong event, or drops a flag that should stay sticky.

// File: rtl/dto_pkg.sv
package dto_pkg;
    typedef enum logic [1:0] {
        W_NONE = 2'd0,
        W_READ = 2'd1,
        W_BUSY = 2'd2,
        W_CRC  = 2'd3
    } wait_e;
endpackage

// File: rtl/dto_event_decode.sv
module dto_event_decode
    import dto_pkg::*;
(
    input  wait_e kind_q,
    input  logic  rd_start,
    input  logic  busy_start,
    input  logic  crc_start,
    input  logic  rd_seen,
    input  logic  busy_gone,
    input  logic  crc_seen,
    output logic  start_any,
    output wait_e start_kind,
    output logic  stop_hit
);
    // fixed start priority: read, then busy, then CRC status
    always_comb begin
        start_any  = rd_start | busy_start | crc_start;
        start_kind = W_NONE;
        if (rd_start)        start_kind = W_READ;
        else if (busy_start) start_kind = W_BUSY;
        else if (crc_start)  start_kind = W_CRC;
    end

    // only the stop belonging to the running kind counts
    always_comb begin
        unique case (kind_q)
            W_READ:  stop_hit = rd_seen;
            W_BUSY:  stop_hit = busy_gone;
            W_CRC:   stop_hit = crc_seen;
            default: stop_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dto_limit.sv
module dto_limit #(
    parameter int BASE_EXP = 13,
    parameter int MAX_CODE = 14,
    parameter int CODE_W   = 4,
    parameter int CNT_W    = BASE_EXP + MAX_CODE + 1
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] code_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [CODE_W-1:0] code_clamped,
    output logic [CNT_W-1:0]  last_val,
    output logic              at_last
);
    localparam logic [CODE_W-1:0] CODE_CAP = CODE_W'(MAX_CODE);
    localparam logic [CNT_W-1:0]  ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        code_clamped = (code_in > CODE_CAP) ? CODE_CAP : code_in;
        last_val     = (ONE << (BASE_EXP + int'(code_q))) - ONE;
        at_last      = (cnt_q == last_val);
    end
endmodule

// File: rtl/dat_timeout_unit.sv
module dat_timeout_unit
    import dto_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int MAX_CODE = 14,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              tick_en,
    input  logic              rd_start,
    input  logic              busy_start,
    input  logic              crc_start,
    input  logic              rd_seen,
    input  logic              busy_gone,
    input  logic              crc_seen,
    input  logic              err_clr,
    input  logic              dat_sreset,
    output logic              tmo_err
);
    localparam int CNT_W = BASE_EXP + MAX_CODE + 1;

    typedef struct packed {
        wait_e             kind;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic              start_any, stop_hit, at_last;
    wait_e             start_kind;
    logic [CODE_W-1:0] code_clamped;
    logic [CNT_W-1:0]  last_val;

    dto_event_decode u_dec (
        .kind_q     (st_q.kind),
        .rd_start   (rd_start),
        .busy_start (busy_start),
        .crc_start  (crc_start),
        .rd_seen    (rd_seen),
        .busy_gone  (busy_gone),
        .crc_seen   (crc_seen),
        .start_any  (start_any),
        .start_kind (start_kind),
        .stop_hit   (stop_hit)
    );

    dto_limit #(
        .BASE_EXP (BASE_EXP),
        .MAX_CODE (MAX_CODE),
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W)
    ) u_lim (
        .code_in      (tmo_code),
        .code_q       (st_q.code),
        .cnt_q        (st_q.cnt),
        .code_clamped (code_clamped),
        .last_val     (last_val),
        .at_last      (at_last)
    );

    always_comb begin
        st_d = st_q;
        if (err_clr) st_d.err = 1'b0;
        if (start_any) begin
            st_d.kind = start_kind;
            st_d.code = code_clamped;
            st_d.cnt  = '0;
        end else if (st_q.kind != W_NONE) begin
            if (stop_hit) begin
                st_d.kind = W_NONE;
                st_d.cnt  = '0;
            end else if (tick_en) begin
                if (at_last) begin
                    st_d.err  = 1'b1;
                    st_d.kind = W_NONE;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
        if (dat_sreset) begin
            st_d.kind = W_NONE;
            st_d.cnt  = '0;
            st_d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.kind <= W_NONE;
            st_q.code <= '0;
            st_q.cnt  <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_err = st_q.err;

    assert_code_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.code <= CODE_W'(MAX_CODE));

    assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_val);

    assert_err_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> $past(tick_en && st_q.kind != W_NONE));

    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind != W_NONE && !tick_en && !start_any && !dat_sreset && !stop_hit)
        |=> $stable(st_q.cnt));

    assert_stop_ends_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && !start_any) |=> (st_q.kind == W_NONE && !$rose(tmo_err)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err && !err_clr && !dat_sreset) |=> tmo_err);

    assert_sreset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dat_sreset |=> (!tmo_err && st_q.kind == W_NONE));
endmodule

// File: tb/tb_dat_timeout_unit.sv
`timescale 1ns/1ps
module tb_dat_timeout_unit;
    localparam int BASE = 1;
    localparam int MAXC = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] tmo_code = '0;
    logic tick_en = 0, rd_start = 0, busy_start = 0, crc_start = 0;
    logic rd_seen = 0, busy_gone = 0, crc_seen = 0, err_clr = 0, dat_sreset = 0;
    logic tmo_err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dat_timeout_unit #(.BASE_EXP(BASE), .MAX_CODE(MAXC), .CODE_W(4)) dut (
        .clk, .rst_n, .tmo_code, .tick_en, .rd_start, .busy_start, .crc_start,
        .rd_seen, .busy_gone, .crc_seen, .err_clr, .dat_sreset, .tmo_err
    );

    function automatic int exp_len(int code);
        int c = (code > MAXC) ? MAXC : code;
        return 1 << (BASE + c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        tick_en = 0; rd_start = 0; busy_start = 0; crc_start = 0;
        rd_seen = 0; busy_gone = 0; crc_seen = 0; err_clr = 0; dat_sreset = 0;
    endtask

    task automatic start(input int kind, input int code);
        tmo_code = 4'(code);
        if (kind == 0) rd_start = 1;
        else if (kind == 1) busy_start = 1;
        else crc_start = 1;
        cyc();
    endtask

    task automatic stop(input int kind);
        if (kind == 0) rd_seen = 1;
        else if (kind == 1) busy_gone = 1;
        else crc_seen = 1;
        cyc();
    endtask

    task automatic ticks(input int n, input int density);
        int given = 0;
        while (given < n) begin
            if (($urandom % 100) < density) begin
                tick_en = 1;
                given++;
            end
            cyc();
        end
    endtask

    task automatic clear_err();
        err_clr = 1;
        cyc();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int len;
        void'($urandom(32'h5eed_1234));
        #9 rst_n = 1;
        #1;
        cyc();
        check(tmo_err == 0, "R1 reset err", int'(tmo_err), 0);
        ticks(10, 100);
        check(tmo_err == 0, "R1 idle no error", int'(tmo_err), 0);

        // R2 exact terminal tick, code 0 and 3
        for (int c = 0; c < 4; c += 3) begin
            len = exp_len(c);
            start(0, c);
            ticks(len - 1, 100);
            check(tmo_err == 0, "R2 before terminal", int'(tmo_err), 0);
            ticks(1, 100);
            check(tmo_err == 1, "R2 at terminal", int'(tmo_err), 1);
            clear_err();
            check(tmo_err == 0, "R8 w1c clears", int'(tmo_err), 0);
        end

        // R4 sparse ticks: idle cycles do not count
        start(1, 2);
        ticks(exp_len(2) - 1, 20);
        repeat (20) cyc();
        check(tmo_err == 0, "R4 idle cycles ignored", int'(tmo_err), 0);
        ticks(1, 100);
        check(tmo_err == 1, "R4 sparse terminal", int'(tmo_err), 1);
        repeat (30) cyc();
        check(tmo_err == 1, "R8 sticky", int'(tmo_err), 1);
        clear_err();

        // R5 restart mid-wait, and start with a tick in the same cycle
        start(2, 3);
        ticks(5, 100);
        tick_en = 1;
        start(2, 3);
        ticks(exp_len(3) - 1, 100);
        check(tmo_err == 0, "R5 restart cleared count", int'(tmo_err), 0);
        ticks(1, 100);
        check(tmo_err == 1, "R5 restart terminal", int'(tmo_err), 1);
        clear_err();

        // R6 wrong stop ignored, right stop halts
        start(1, 2);
        ticks(3, 100);
        stop(0);
        stop(2);
        ticks(exp_len(2) - 3, 100);
        check(tmo_err == 1, "R6 wrong stop ignored", int'(tmo_err), 1);
        clear_err();
        start(1, 2);
        ticks(3, 100);
        stop(1);
        ticks(exp_len(2) * 2, 100);
        check(tmo_err == 0, "R6 matching stop halts", int'(tmo_err), 0);

        // R7 priority among simultaneous starts
        tmo_code = 4'd2; rd_start = 1; crc_start = 1;
        cyc();
        ticks(2, 100);
        stop(2);
        ticks(exp_len(2) - 2, 100);
        check(tmo_err == 1, "R7 read wins over crc", int'(tmo_err), 1);
        clear_err();
        tmo_code = 4'd2; busy_start = 1; crc_start = 1;
        cyc();
        ticks(2, 100);
        stop(1);
        ticks(exp_len(2) * 2, 100);
        check(tmo_err == 0, "R7 busy wins over crc", int'(tmo_err), 0);

        // R8 set and clear in the same cycle
        start(0, 1);
        ticks(exp_len(1) - 1, 100);
        tick_en = 1; err_clr = 1;
        cyc();
        check(tmo_err == 1, "R8 set beats clear", int'(tmo_err), 1);
        clear_err();

        // R9 soft reset abandons wait and clears error
        start(0, 2);
        ticks(exp_len(2), 100);
        dat_sreset = 1;
        cyc();
        check(tmo_err == 0, "R9 sreset clears err", int'(tmo_err), 0);
        start(1, 2);
        ticks(3, 100);
        dat_sreset = 1;
        cyc();
        ticks(exp_len(2) * 2, 100);
        check(tmo_err == 0, "R9 sreset abandons wait", int'(tmo_err), 0);

        // R10 code captured at start
        start(2, 2);
        tmo_code = 4'd6;
        ticks(exp_len(2) - 1, 100);
        check(tmo_err == 0, "R10 before captured end", int'(tmo_err), 0);
        ticks(1, 100);
        check(tmo_err == 1, "R10 captured length used", int'(tmo_err), 1);
        clear_err();

        // random trials
        for (int t = 0; t < 40; t++) begin
            int c = int'($urandom % 8);
            int k = int'($urandom % 3);
            int dens = 30 + int'($urandom % 71);
            bit early = ($urandom % 3) == 0;
            len = exp_len(c);
            start(k, c);
            if (early) begin
                ticks(int'($urandom % len), dens);
                stop(k);
                ticks(len, dens);
                check(tmo_err == 0, "R6 random early stop", int'(tmo_err), 0);
            end else begin
                ticks(len - 1, dens);
                check(tmo_err == 0, "R2 random before end", int'(tmo_err), 0);
                ticks(1, dens);
                check(tmo_err == 1, "R2 random at end", int'(tmo_err), 1);
                clear_err();
            end
        end

        // R2 code 14 and R3 reserved code 15
        for (int c = 14; c <= 15; c++) begin
            start(0, c);
            ticks(exp_len(14) - 1, 100);
            check(tmo_err == 0, c == 14 ? "R2 code14 before end" : "R3 code15 before end", int'(tmo_err), 0);
            ticks(1, 100);
            check(tmo_err == 1, c == 14 ? "R2 code14 at end" : "R3 code15 at end", int'(tmo_err), 1);
            clear_err();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule